// File: doc/BRIEF.md
# Receive FIFO and Interrupt Identification Unit for a Serial Port

This block sits on the receive side of a serial port that runs with its FIFO enabled. Each time the deserializer completes a character, it presents the character for one clock together with its parity, framing and break flags. The block stores the character in an internal queue of `DEPTH` entries (16 by default). The host takes characters from the head of the queue one at a time by pulsing a read strobe. Error flags and queue overruns collect in a sticky line-status vector, which the host clears with a separate strobe.

The block raises three interrupt sources and folds them into one request line and a four-bit identification code:
- a line-status interrupt;
- a fill-level ("data available") interrupt, with a trigger threshold the host can select;
- a character time-out interrupt.

The time-out counts a bit-rate tick derived from the receive clock. It fires when the queue holds data and neither a reception nor a host read has happened for four frame times. The caller gives the frame length in bits, including a second stop bit when one is configured, so the delay follows the baud rate.

Top module: `uart_rxq_irq`

## Requirements
- R1: After reset the queue is empty, `fill` is 0, `data_ready` is 0, `lsr_flags` is 0, `irq` is 0 and `iid` is 4'b0001 (nothing pending).
- R2: Characters leave the queue in arrival order, and `rd_data` always shows the oldest stored character. A read strobe while the queue is empty changes nothing.
- R3: `data_ready` goes high on the clock edge that stores a character. It goes low only when the queue becomes empty.
- R4: A character that arrives while the queue holds `DEPTH` entries, with no read in the same cycle, is discarded and sets `lsr_flags[0]` (overrun). The stored characters are kept.
- R5: The threshold is set by `trig_sel`: 0 gives 1 entry, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives DEPTH-2 (1, 4, 8, 14 by default). Data-available (`iid` 4'b0100) is shown while `fill` is at or above the threshold, and stops as soon as `fill` drops below it.
- R6: Data-available and time-out are reported only while both `fifo_en` and `rdi_en` are 1.
- R7: A received character's parity, framing or break flag sets `lsr_flags[1]`, `[2]` or `[3]` respectively. Any set bit, with `lsi_en` high, gives `iid` 4'b0110, which overrides the other sources. A `lsr_rd` pulse clears all four bits.
- R8: A time-out (`iid` 4'b1100) becomes pending one clock after `4*frame_bits` bit ticks have passed with data in the queue and no reception and no host read. One tick fewer is not enough.
- R9: A reception while a time-out is pending does not clear it. A single host read clears it and restarts the count from zero.
- R10: While no time-out is pending, a reception or a host read restarts the count from zero.
- R11: When data-available and time-out are both active, `iid` shows data-available. `irq` is 1 exactly when `iid` is not 4'b0001.
- R12: The time-out threshold follows `frame_bits`, so a 12-bit frame (two stop bits) needs 48 ticks where a 10-bit frame needs 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_vld | input | 1 | One-cycle strobe: a received character is complete |
| chr_data | input | DW | Received character |
| chr_perr | input | 1 | Parity error of the received character |
| chr_ferr | input | 1 | Framing error of the received character |
| chr_brk | input | 1 | Break detected with the received character |
| rd_stb | input | 1 | Host reads one character from the queue head |
| lsr_rd | input | 1 | Host reads line status; clears the sticky flags |
| fifo_en | input | 1 | Queue mode enable |
| rdi_en | input | 1 | Receive-data interrupt enable |
| lsi_en | input | 1 | Line-status interrupt enable |
| trig_sel | input | 2 | Data-available threshold select |
| frame_bits | input | FRW | Bits per frame, second stop bit included |
| bit_tick | input | 1 | One pulse per bit time from the receive clock |
| rd_data | output | DW | Character at the queue head |
| fill | output | CW | Number of stored characters |
| data_ready | output | 1 | Queue holds at least one character |
| lsr_flags | output | 4 | Sticky {break, framing, parity, overrun} |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a pending time-out that must survive a new reception and then restart cleanly after exactly one read. It needs a precise count of tick pulses with no events in between. The bench reaches it by storing one character and issuing exactly `4*frame_bits - 1` ticks, then one more, checking the code on both sides of the boundary. It then pushes a second character while the time-out is pending, reads once, and counts a fresh full window. The overrun path is reached by filling all sixteen entries with a sequence and then checking that the seventeenth value never appears when the queue is drained.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [3:0] {
      IID_NONE  = 4'b0001,
      IID_LSTAT = 4'b0110,
      IID_RDATA = 4'b0100,
      IID_TOUT  = 4'b1100
   } iid_e;

   // fill threshold for each select value
   function automatic int unsigned trig_depth(input logic [1:0] sel, input int unsigned depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic [DW-1:0] push_data,
   input  logic          pop_req,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          ovr
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic          full, empty;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign pop_ok  = pop_req && !empty;
   assign push_ok = push_req && (!full || pop_ok);
   assign ovr     = push_req && full && !pop_ok;
   assign head    = mem[rptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wnext;
         if (pop_ok)  rptr <= rnext;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH)); // R4
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop_req && !push_req) |=> (count == '0)); // R2

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
   parameter int FRW  = 4,
   localparam int TW  = FRW + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           rx_evt,
   input  logic           rd_evt,
   input  logic           nonempty,
   input  logic [FRW-1:0] frame_bits,
   output logic           pend
);
   logic [TW-1:0] limit, tmr;

   assign limit = {frame_bits, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr  <= '0;
         pend <= 1'b0;
      end else if (rd_evt) begin
         tmr  <= '0;
         pend <= 1'b0;
      end else begin
         if (rx_evt && !pend)          tmr <= '0;
         else if (tick && tmr < limit) tmr <= tmr + 1'b1;
         if (!pend && nonempty && !rx_evt && tmr >= limit) pend <= 1'b1;
      end
   end

   AST_TO_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n) pend |-> nonempty); // R8
   AST_TO_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n) (pend && rd_evt) |=> !pend); // R9
   AST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pend && !rd_evt) |=> pend); // R9

endmodule

// File: rtl/rxq_prio.sv
module rxq_prio
   import rxq_pkg::*;
(
   input  logic       ls_act,
   input  logic       rda_act,
   input  logic       to_act,
   output logic [3:0] iid,
   output logic       irq
);
   iid_e code;

   always_comb begin
      if (ls_act)       code = IID_LSTAT;
      else if (rda_act) code = IID_RDATA;
      else if (to_act)  code = IID_TOUT;
      else              code = IID_NONE;
   end

   assign iid = code;
   assign irq = (code != IID_NONE);

endmodule

// File: rtl/uart_rxq_irq.sv
module uart_rxq_irq
   import rxq_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   parameter int FRW   = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           chr_vld,
   input  logic [DW-1:0]  chr_data,
   input  logic           chr_perr,
   input  logic           chr_ferr,
   input  logic           chr_brk,
   input  logic           rd_stb,
   input  logic           lsr_rd,
   input  logic           fifo_en,
   input  logic           rdi_en,
   input  logic           lsi_en,
   input  logic [1:0]     trig_sel,
   input  logic [FRW-1:0] frame_bits,
   input  logic           bit_tick,
   output logic [DW-1:0]  rd_data,
   output logic [CW-1:0]  fill,
   output logic           data_ready,
   output logic [3:0]     lsr_flags,
   output logic [3:0]     iid,
   output logic           irq
);
   generate
      if (DEPTH < 8) begin : g_bad_depth
         initial $fatal(1, "uart_rxq_irq: DEPTH must be at least 8");
      end
      if (DW < 5 || FRW < 2) begin : g_bad_width
         initial $fatal(1, "uart_rxq_irq: DW >= 5 and FRW >= 2 required");
      end
   endgenerate

   logic          push_ok, pop_ok, ovr, to_pend;
   logic [CW-1:0] level;
   logic [3:0]    lsr_q, lsr_set;
   logic          ls_act, rda_act, to_act, rx_on;

   rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .push_req(chr_vld), .push_data(chr_data), .pop_req(rd_stb),
      .head(rd_data), .count(fill),
      .push_ok(push_ok), .pop_ok(pop_ok), .ovr(ovr)
   );

   rxq_timer #(.FRW(FRW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .tick(bit_tick), .rx_evt(chr_vld), .rd_evt(pop_ok),
      .nonempty(fill != '0), .frame_bits(frame_bits), .pend(to_pend)
   );

   // sticky line status: bit3 break, bit2 framing, bit1 parity, bit0 overrun
   assign lsr_set = {chr_vld & chr_brk, chr_vld & chr_ferr, chr_vld & chr_perr, ovr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lsr_q <= '0;
      else        lsr_q <= (lsr_rd ? 4'b0000 : lsr_q) | lsr_set;
   end

   assign lsr_flags  = lsr_q;
   assign data_ready = (fill != '0);
   assign level      = CW'(trig_depth(trig_sel, DEPTH));
   assign rx_on      = fifo_en & rdi_en;
   assign ls_act     = lsi_en & (|lsr_q);
   assign rda_act    = rx_on & (fill >= level);
   assign to_act     = rx_on & to_pend;

   rxq_prio u_prio (
      .ls_act(ls_act), .rda_act(rda_act), .to_act(to_act),
      .iid(iid), .irq(irq)
   );

   AST_DR_SET: assert property (@(posedge clk) disable iff (!rst_n) push_ok |=> data_ready); // R3
   AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n) ovr |=> lsr_flags[0]); // R4
   AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (lsi_en && lsr_flags != 4'b0) |-> (iid == 4'b0110)); // R7
   AST_RDA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && fill >= level && !(lsi_en && lsr_flags != 4'b0)) |-> (iid == 4'b0100)); // R5
   AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |-> (iid == 4'b0001 || iid == 4'b0110)); // R6

endmodule

// File: tb/uart_rxq_irq_test.sv
`timescale 1ns/1ps
module uart_rxq_irq_test;
   localparam int DW = 8, DEPTH = 16, FRW = 4, CW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic chr_vld = 0, chr_perr = 0, chr_ferr = 0, chr_brk = 0;
   logic [DW-1:0] chr_data = '0;
   logic rd_stb = 0, lsr_rd = 0, fifo_en = 1, rdi_en = 0, lsi_en = 0, bit_tick = 0;
   logic [1:0] trig_sel = 2'd0;
   logic [FRW-1:0] frame_bits = 4'd10;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] fill;
   logic data_ready, irq;
   logic [3:0] lsr_flags, iid;

   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   uart_rxq_irq #(.DW(DW), .DEPTH(DEPTH), .FRW(FRW)) uut (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
      .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk),
      .rd_stb(rd_stb), .lsr_rd(lsr_rd), .fifo_en(fifo_en), .rdi_en(rdi_en),
      .lsi_en(lsi_en), .trig_sel(trig_sel), .frame_bits(frame_bits),
      .bit_tick(bit_tick), .rd_data(rd_data), .fill(fill),
      .data_ready(data_ready), .lsr_flags(lsr_flags), .iid(iid), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [DW-1:0] d, input logic [2:0] fl = 3'b000);
      @(negedge clk);
      chr_vld = 1; chr_data = d; {chr_brk, chr_ferr, chr_perr} = fl;
      @(negedge clk);
      chr_vld = 0; {chr_brk, chr_ferr, chr_perr} = 3'b000;
   endtask

   task automatic pop(output logic [DW-1:0] d);
      @(negedge clk);
      d = rd_data; rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bit_tick = 1;
         @(negedge clk); bit_tick = 0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      logic [DW-1:0] d;
      while (fill != 0) pop(d);
   endtask

   task automatic t_reset();
      chk("R1 fill", fill, 0);
      chk("R1 data_ready", data_ready, 0);
      chk("R1 lsr_flags", lsr_flags, 0);
      chk("R1 iid", iid, 4'b0001);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_order();
      logic [DW-1:0] d;
      rdi_en = 0;
      push(8'h11); chk("R3 data_ready after store", data_ready, 1);
      push(8'h22); push(8'h33);
      chk("R2 head", rd_data, 8'h11);
      pop(d); chk("R2 first", d, 8'h11);
      chk("R3 data_ready with 2 left", data_ready, 1);
      pop(d); chk("R2 second", d, 8'h22);
      pop(d); chk("R2 third", d, 8'h33);
      chk("R3 data_ready empty", data_ready, 0);
      pop(d); chk("R2 read on empty fill", fill, 0);
      push(8'hA5);
      chk("R2 head after empty read", rd_data, 8'hA5);
      chk("R2 fill after empty read", fill, 1);
      drain();
   endtask

   task automatic t_trig();
      int lv [4] = '{1, 4, 8, 14};
      logic [DW-1:0] d;
      rdi_en = 1;
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         for (int k = 0; k < lv[s] - 1; k++) push(8'(k));
         chk("R5 below level", iid, 4'b0001);
         push(8'hEE);
         chk("R5 at level", iid, 4'b0100);
         chk("R11 irq at level", irq, 1);
         pop(d);
         chk("R5 dropped below", iid, 4'b0001);
         chk("R11 irq cleared", irq, 0);
         drain();
      end
   endtask

   task automatic t_gate();
      trig_sel = 2'd0; rdi_en = 0; fifo_en = 1;
      push(8'h5A); chk("R6 rdi_en off", iid, 4'b0001);
      rdi_en = 1; fifo_en = 0; idle(1);
      chk("R6 fifo_en off", iid, 4'b0001);
      ticks(40); idle(1);
      chk("R6 timeout gated", iid, 4'b0001);
      fifo_en = 1; idle(1);
      chk("R6 enabled again", iid, 4'b0100);
      drain();
   endtask

   task automatic t_overrun();
      logic [DW-1:0] d;
      trig_sel = 2'd3; rdi_en = 1; lsi_en = 1;
      for (int k = 0; k < DEPTH; k++) push(8'(k + 1));
      chk("R4 no overrun when just full", lsr_flags[0], 0);
      chk("R5 level 14 reached", iid, 4'b0100);
      push(8'hFF);
      chk("R4 overrun flag", lsr_flags[0], 1);
      chk("R4 fill stays", fill, DEPTH);
      chk("R7 line status first", iid, 4'b0110);
      for (int k = 0; k < DEPTH; k++) begin
         pop(d); chk("R4 kept data", d, k + 1);
      end
      chk("R4 discarded char absent", fill, 0);
      @(negedge clk); lsr_rd = 1; @(negedge clk); lsr_rd = 0;
      chk("R7 cleared by lsr_rd", lsr_flags, 0);
      chk("R7 iid after clear", iid, 4'b0001);
   endtask

   task automatic t_errs();
      trig_sel = 2'd0; rdi_en = 1; lsi_en = 1;
      push(8'h01, 3'b001); chk("R7 parity bit", lsr_flags, 4'b0010);
      push(8'h02, 3'b010); chk("R7 framing bit", lsr_flags, 4'b0110);
      push(8'h03, 3'b100); chk("R7 break bit", lsr_flags, 4'b1110);
      chk("R7 iid line status", iid, 4'b0110);
      lsi_en = 0; idle(1);
      chk("R7 masked shows data", iid, 4'b0100);
      @(negedge clk); lsr_rd = 1; @(negedge clk); lsr_rd = 0;
      chk("R7 flags cleared", lsr_flags, 0);
      drain();
   endtask

   task automatic t_timeout();
      logic [DW-1:0] d;
      trig_sel = 2'd3; rdi_en = 1; lsi_en = 1; frame_bits = 4'd10;
      push(8'h41);
      ticks(39); idle(2);
      chk("R8 one tick short", iid, 4'b0001);
      ticks(1); idle(1);
      chk("R8 time-out pending", iid, 4'b1100);
      push(8'h42);
      chk("R9 held over reception", iid, 4'b1100);
      pop(d);
      chk("R9 cleared by one read", iid, 4'b0001);
      ticks(39); idle(2);
      chk("R9 restarted count short", iid, 4'b0001);
      ticks(1); idle(1);
      chk("R9 fires again after restart", iid, 4'b1100);
      drain();
      chk("R8 none when empty", iid, 4'b0001);
   endtask

   task automatic t_restart();
      logic [DW-1:0] d;
      trig_sel = 2'd3; rdi_en = 1; frame_bits = 4'd12;
      push(8'h61); ticks(30);
      push(8'h62); ticks(30); idle(1);
      chk("R10 reception restarts", iid, 4'b0001);
      ticks(17); idle(2);
      chk("R12 47 of 48 ticks", iid, 4'b0001);
      ticks(1); idle(1);
      chk("R12 48 ticks for 12-bit frame", iid, 4'b1100);
      pop(d);
      ticks(20); push(8'h63);
      chk("R9 read cleared", iid, 4'b0001);
      ticks(20); pop(d); ticks(47); idle(1);
      chk("R10 read restarts", iid, 4'b0001);
      ticks(1); idle(1);
      chk("R10 fires after read window", iid, 4'b1100);
      drain();
   endtask

   task automatic t_prio();
      trig_sel = 2'd0; rdi_en = 1; frame_bits = 4'd10;
      push(8'h71); ticks(40); idle(1);
      chk("R11 data beats time-out", iid, 4'b0100);
      trig_sel = 2'd1; idle(1);
      chk("R11 time-out when below level", iid, 4'b1100);
      chk("R11 irq with time-out", irq, 1);
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_order();
      t_trig();
      t_gate();
      t_overrun();
      t_errs();
      t_timeout();
      t_restart();
      t_prio();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule